// File: doc/BRIEF.md
# Byte-Selected Three-State Result Port

This block is the processor-facing read side of a 12-bit successive-approximation converter. It puts the converter's 12-bit result and its conversion-status flag onto an 8-bit three-state data bus. A full result takes two byte reads. A byte-select input picks the upper byte or the lower byte, and software may fetch the two bytes in either order.

The bus is driven only while the active-low chip-select and the active-low read strobe are both asserted. At all other times it floats. The output is purely combinational from the strobes, the byte-select input, the live SAR register and the status flag. No access state is held between reads, so the output follows byte-select at once. A read made during a conversion is not blocked: it returns whatever partial value the SAR holds at that moment.

The port is modelled as an output-enable plus an 8-bit data vector. A three-state wire is also provided, and it floats whenever the enable is low.

Top module: `rdport`

## Requirements
- R1: `busOe` is 1 exactly when `csN` and `rdN` are both 0. Otherwise it is 0 and `busLine` is high impedance.
- R2: With `byteSel` = 1 (upper byte), `busData[7]` is the status flag, `busData[6:4]` are 0, and `busData[3:0]` are `sarBits[11:8]`.
- R3: With `byteSel` = 0 (lower byte), `busData[7:0]` are `sarBits[7:0]`. The result is right-justified: `sarBits[0]` is the LSB and `sarBits[11]` is the MSB.
- R4: The status bit (`busData[7]` in an upper-byte read) is 1 while `convBusy` is 1 and 0 while it is 0, following it in the same cycle.
- R5: If `byteSel` changes while `csN` and `rdN` are both 0, `busData` shows the newly selected byte in the same cycle, with no intervening strobe.
- R6: A read while `convBusy` = 1 returns the current, partial `sarBits` value, and it tracks each change of `sarBits` during the read.
- R7: Reading the lower byte then the upper byte, or the upper byte then the lower byte, gives the same 12-bit value for a stable result.
- R8: While `busOe` = 1, `busLine` equals `busData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| byteSel | input | 1 | 1 selects status and upper result bits, 0 selects lower result bits |
| sarBits | input | 12 | Live contents of the conversion register |
| convBusy | input | 1 | Conversion-status flag, 1 while a conversion runs |
| busOe | output | 1 | Bus output enable |
| busData | output | 8 | Selected byte, valid while busOe is 1 |
| busLine | output | 8 | Three-state bus, floats while busOe is 0 |

## Verification
Two functions can fall in the same cycle: a change of byte-select during an enabled read, and a change of the SAR contents or the status flag during a conversion. The bench provokes this by driving a new `byteSel`, a new `sarBits` value and a toggled `convBusy` in one step, with the strobes held low. It judges the result by comparing the bus against a behavioural model that recomputes the expected byte from the new inputs only. A stale byte or a stale flag therefore shows up as a mismatch in that cycle.

// File: rtl/rdport_pkg.sv
package rdport_pkg;
  typedef struct packed {
    logic drive;     // bus enabled
    logic pickHigh;  // upper byte selected
  } rdStrobe_t;
endpackage

// File: rtl/rdport_ctrl.sv
module rdport_ctrl
  import rdport_pkg::*;
(
  input  logic       csN,
  input  logic       rdN,
  input  logic       byteSel,
  output rdStrobe_t  strobe
);
  always_comb begin
    strobe.drive    = ~(csN | rdN);
    strobe.pickHigh = byteSel;
  end
endmodule

// File: rtl/rdport_dpath.sv
module rdport_dpath
  import rdport_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int BUS_W = 8
) (
  input  rdStrobe_t          strobe,
  input  logic [RES_W-1:0]   sarBits,
  input  logic               convBusy,
  output logic               busOe,
  output logic [BUS_W-1:0]   busData
);
  localparam int HI_W  = RES_W - BUS_W;
  localparam int PAD_W = BUS_W - 1 - HI_W;

  logic [BUS_W-1:0] hiByte;
  logic [BUS_W-1:0] loByte;

  assign hiByte[BUS_W-1] = convBusy;

  genvar i;
  generate
    for (i = 0; i < BUS_W - 1; i++) begin : g_hi
      if (i < HI_W) begin : g_res
        assign hiByte[i] = sarBits[BUS_W + i];
      end else begin : g_pad
        assign hiByte[i] = 1'b0;
      end
    end
  endgenerate

  assign loByte = sarBits[BUS_W-1:0];

  always_comb begin
    busOe   = strobe.drive;
    busData = strobe.pickHigh ? hiByte : loByte;
  end

  always_comb begin
    if (strobe.pickHigh) begin
      // R2
      hi_pad_zero_chk: assert (busData[BUS_W-2 -: PAD_W] == '0);
      // R4
      busy_flag_chk: assert (busData[BUS_W-1] == convBusy);
    end else begin
      // R3
      lo_byte_chk: assert (busData == sarBits[BUS_W-1:0]);
    end
  end
endmodule

// File: rtl/rdport.sv
module rdport
  import rdport_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int BUS_W = 8
) (
  input  logic               csN,
  input  logic               rdN,
  input  logic               byteSel,
  input  logic [RES_W-1:0]   sarBits,
  input  logic               convBusy,
  output logic               busOe,
  output logic [BUS_W-1:0]   busData,
  output wire  [BUS_W-1:0]   busLine
);
  rdStrobe_t strobe;

  rdport_ctrl u_ctrl (
    .csN     (csN),
    .rdN     (rdN),
    .byteSel (byteSel),
    .strobe  (strobe)
  );

  rdport_dpath #(.RES_W(RES_W), .BUS_W(BUS_W)) u_dpath (
    .strobe   (strobe),
    .sarBits  (sarBits),
    .convBusy (convBusy),
    .busOe    (busOe),
    .busData  (busData)
  );

  assign busLine = busOe ? busData : {BUS_W{1'bz}};

  always_comb begin
    // R1
    oe_gate_chk: assert (busOe == (!csN && !rdN));
    // R8
    if (busOe) line_match_chk: assert (busLine == busData);
  end
endmodule

// File: tb/sim_rdport.sv
module sim_rdport;
  logic        clk = 1'b0;
  logic        csN = 1'b1, rdN = 1'b1, byteSel = 1'b0, convBusy = 1'b0;
  logic [11:0] sarBits = '0;
  logic        busOe;
  logic [7:0]  busData;
  wire  [7:0]  busLine;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  rdport u0 (
    .csN(csN), .rdN(rdN), .byteSel(byteSel), .sarBits(sarBits),
    .convBusy(convBusy), .busOe(busOe), .busData(busData), .busLine(busLine)
  );

  function automatic int modelByte(bit hi, int sar, bit busy);
    if (hi) return (busy ? 128 : 0) + ((sar / 256) % 16);
    return sar % 256;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(bit c, bit r, bit s, int sar, bit busy);
    csN = c; rdN = r; byteSel = s; sarBits = sar[11:0]; convBusy = busy;
    @(posedge clk); #2;
  endtask

  // per-clock comparison against the behavioural model (R1, R8)
  always @(negedge clk) begin
    chk("R1 oe", int'(busOe), int'(!csN && !rdN));
    if (busOe) begin
      chk("R8 line", int'(busLine), int'(busData));
      chk("R2/R3 byte", int'(busData), modelByte(byteSel, int'(sarBits), convBusy));
    end
  end

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lo, hi, r1;
    @(posedge clk); #2;
    // reset state (R1)
    chk("R1 idle", int'(busOe), 0);
    step(1, 0, 0, 12'hABC, 0); chk("R1 cs high", int'(busOe), 0);
    step(0, 1, 0, 12'hABC, 0); chk("R1 rd high", int'(busOe), 0);
    step(0, 0, 0, 12'hABC, 0); chk("R1 enabled", int'(busOe), 1);
    // R3 low byte
    chk("R3 low", int'(busData), 8'hBC);
    // R2 high byte with pad
    step(0, 0, 1, 12'hFFF, 0); chk("R2 high", int'(busData), 8'h0F);
    step(0, 0, 1, 12'h5A3, 1); chk("R2 high busy", int'(busData), 8'h85);
    // R4 flag follows
    step(0, 0, 1, 12'h5A3, 0); chk("R4 flag low", int'(busData[7]), 0);
    step(0, 0, 1, 12'h5A3, 1); chk("R4 flag high", int'(busData[7]), 1);
    // R5 byteSel toggle under enabled strobes
    step(0, 0, 0, 12'h5A3, 1); chk("R5 to low", int'(busData), 8'hA3);
    step(0, 0, 1, 12'h5A3, 1); chk("R5 to high", int'(busData), 8'h85);
    // R6 partial contents during conversion, sel and sar change together
    step(0, 0, 0, 12'h800, 1); chk("R6 partial", int'(busData), 8'h00);
    step(0, 0, 1, 12'hC00, 0); chk("R6 partial hi", int'(busData), 8'h0C);
    step(0, 0, 0, 12'hC40, 1); chk("R6 track", int'(busData), 8'h40);
    // R7 either order
    step(0, 0, 0, 12'h7E1, 0); lo = int'(busData);
    step(1, 1, 0, 12'h7E1, 0);
    step(0, 0, 1, 12'h7E1, 0); hi = int'(busData);
    r1 = (hi % 16) * 256 + lo;
    step(1, 1, 1, 12'h7E1, 0);
    step(0, 0, 1, 12'h7E1, 0); hi = int'(busData);
    step(0, 0, 0, 12'h7E1, 0); lo = int'(busData);
    chk("R7 low-first", r1, 12'h7E1);
    chk("R7 high-first", (hi % 16) * 256 + lo, r1);
    // random stimulus, checked by the per-clock model
    for (int k = 0; k < 3000; k++) begin
      step(bit'($urandom_range(0, 3) == 0), bit'($urandom_range(0, 3) == 0),
           bit'($urandom_range(0, 1)), int'($urandom_range(0, 4095)),
           bit'($urandom_range(0, 1)));
    end
    step(1, 1, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule